// File: doc/BRIEF.md
# Two-Bank Interrupt Controller with Fast/Normal Steering

This block gathers forty level-sensitive interrupt sources and turns them into two processor request lines: a fast request and a normal request. Each source has an enable bit and a steering bit. An enabled source whose input is high drives the fast line when its steering bit is 1 and the normal line when it is 0. The per-source state is held as two 32-bit banks. The low bank carries sources 0 to 31. The high bank carries the remaining eight sources in its low bits.

A third output, the wake request, is raised while the processor reports that it is halted. By default any source whose input is high can wake the processor, whether enabled or not. Setting one control bit narrows waking to enabled sources only. Software reaches the state through a word-addressed 32-bit read/write bus. The bus also holds a table of forty priority entries. The word that names the winning source comes from an external resolver and is only passed through on reads.

Top module: `dbank_intc`

## Requirements
- R1: Source n (n < 32) occupies bit n of the low bank; source n (32 ≤ n < 40) occupies bit n−32 of the high bank. High-bank bits 31:8 always read as zero.
- R2: The raw pending registers (low bank at 0x10, high bank at 0xAC) copy the source inputs on every clock edge with no latching, so a read after one edge shows the current input levels.
- R3: `fiq_o` is 1 one clock edge after a cycle in which some source input is high with its enable bit 1 and its steering bit 1, and is 0 one edge after a cycle where none is.
- R4: `irq_o` is 1 one clock edge after a cycle in which some source input is high with its enable bit 1 and its steering bit 0, and is 0 one edge after a cycle where none is.
- R5: The normal-pending read (0x00 low, 0x9C high) returns pending AND NOT steering AND enable. The fast-pending read (0x0C low, 0xA8 high) returns pending AND steering AND enable.
- R6: The enable registers (0x04 low, 0xA0 high) and the steering registers (0x08 low, 0xA4 high) read back the last value written, limited to existing sources.
- R7: Control bit 0 at offset 0x14 reads back as written. `wake_o` is 1 one edge after a cycle with `halted_i` high and some source high that is enabled, or any high source at all when control bit 0 is 0.
- R8: Priority entry k sits at 0x1C+4k for k < 32 and at 0xB0+4(k−32) for 32 ≤ k < 40. A write keeps only bit 31 and bits 5:0; all other bits read as zero.
- R9: Reset (active-low, synchronous) clears enables, steering, pending, control bit 0 and every priority entry, and drives all three outputs low.
- R10: Writes to an offset outside the map, or to a read-only offset (the pending reads and 0x18), change nothing. Reads outside the map return zero. A read of 0x18 returns `hp_word_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| src_i | input | 40 | Source input levels |
| halted_i | input | 1 | Processor reports it is halted |
| bus_wr_i | input | 1 | Write strobe, applied at the clock edge |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| hp_word_i | input | 32 | Winning-source word from the external resolver |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| wake_o | output | 1 | Wake request while halted |

## Verification
Read data is combinational from the address, so the bench samples it at the falling edge in the same cycle the address is set. A register write lands at the rising edge of its cycle, and a source change is captured into the pending state at the next rising edge. The three request outputs come one register stage later: one edge after a source change, and two edges after a write that changes enables, steering or control. Each task drives at a falling edge, waits for the edges that the affected result needs, and samples at the following falling edge.

// File: rtl/dbi_pkg.sv
// Shared constants and types for the two-bank interrupt controller.
// Assumes byte offsets fit in 8 bits and registers are 32 bits wide.
package dbi_pkg;
    localparam int ADDR_W = 8;
    localparam int REG_W  = 32;

    // Register offsets; the priority-table bases define entry decoding.
    localparam logic [ADDR_W-1:0] OFS_IRQ_LO  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_ENA_LO  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STR_LO  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_FIQ_LO  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_RAW_LO  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_WINNER  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_PRI_LO  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_IRQ_HI  = 8'h9C;
    localparam logic [ADDR_W-1:0] OFS_ENA_HI  = 8'hA0;
    localparam logic [ADDR_W-1:0] OFS_STR_HI  = 8'hA4;
    localparam logic [ADDR_W-1:0] OFS_FIQ_HI  = 8'hA8;
    localparam logic [ADDR_W-1:0] OFS_RAW_HI  = 8'hAC;
    localparam logic [ADDR_W-1:0] OFS_PRI_HI  = 8'hB0;

    // One stored priority entry: the valid flag (bit 31) and source id (bits 5:0).
    typedef struct packed {
        logic       vld;
        logic [5:0] id;
    } prio_ent_t;

    // Byte offset of priority entry k.
    function automatic logic [ADDR_W-1:0] prio_ofs(input int k);
        if (k < 32) return OFS_PRI_LO + ADDR_W'(4 * k);
        else        return OFS_PRI_HI + ADDR_W'(4 * (k - 32));
    endfunction
endpackage

// File: rtl/dbi_src_bank.sv
// Source state for both banks: enable, steering, pending and the idle control.
// Computes the registered fast, normal and wake requests.
// Assumes 32 < NUM_SRC <= 64 so the high bank is partly populated.
module dbi_src_bank
    import dbi_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               halted_i,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  waddr_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [NUM_SRC-1:0] ena_o,
    output logic [NUM_SRC-1:0] str_o,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               idle_dis_o,
    output logic               fiq_o,
    output logic               irq_o,
    output logic               wake_o
);
    localparam int HI_W = NUM_SRC - REG_W;

    logic [NUM_SRC-1:0] ena_q, str_q, pend_q;
    logic               idle_dis_q;
    logic [NUM_SRC-1:0] live;
    logic [NUM_SRC-1:0] wake_set;

    // Pending copies the inputs every edge; reset clears it.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) pend_q <= '0;
        else         pend_q <= src_i;
    end

    // Software-written enable, steering and idle control registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ena_q      <= '0;
            str_q      <= '0;
            idle_dis_q <= 1'b0;
        end else if (wr_i) begin
            unique case (waddr_i)
                OFS_ENA_LO: ena_q[REG_W-1:0]       <= wdata_i;
                OFS_ENA_HI: ena_q[NUM_SRC-1:REG_W] <= wdata_i[HI_W-1:0];
                OFS_STR_LO: str_q[REG_W-1:0]       <= wdata_i;
                OFS_STR_HI: str_q[NUM_SRC-1:REG_W] <= wdata_i[HI_W-1:0];
                OFS_CTRL:   idle_dis_q             <= wdata_i[0];
                default: ;
            endcase
        end
    end

    // Sources that are high and enabled; wake set widens with the idle mask.
    always_comb begin
        live     = src_i & ena_q;
        wake_set = src_i & (ena_q | {NUM_SRC{~idle_dis_q}});
    end

    // Output requests, one register stage after inputs and state.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fiq_o  <= 1'b0;
            irq_o  <= 1'b0;
            wake_o <= 1'b0;
        end else begin
            fiq_o  <= |(live & str_q);
            irq_o  <= |(live & ~str_q);
            wake_o <= halted_i & (|wake_set);
        end
    end

    assign ena_o      = ena_q;
    assign str_o      = str_q;
    assign pend_o     = pend_q;
    assign idle_dis_o = idle_dis_q;
endmodule

// File: rtl/dbi_prio_table.sv
// Table of NUM_SRC priority entries, each holding a valid flag and a source id.
// A write stores bit 31 and bits 5:0 only. Read is combinational with a hit flag.
module dbi_prio_table
    import dbi_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              hit_o
);
    prio_ent_t          ent_q [NUM_SRC];
    logic [NUM_SRC-1:0] sel;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_ent
        localparam logic [ADDR_W-1:0] MY_OFS = prio_ofs(k);
        assign sel[k] = (addr_i == MY_OFS);

        // Entry storage with the write mask applied.
        always_ff @(posedge clk_i) begin
            if (!rst_ni)              ent_q[k] <= '0;
            else if (wr_i && sel[k])  ent_q[k] <= '{vld: wdata_i[31], id: wdata_i[5:0]};
        end
    end

    // Read mux over the selected entry.
    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (sel[k]) rdata_o = {ent_q[k].vld, 25'b0, ent_q[k].id};
        end
        hit_o = |sel;
    end
endmodule

// File: rtl/dbi_read_mux.sv
// Combinational register read decode for the controller.
// Assumes the priority table reports its own hits; anything else unmapped reads zero.
module dbi_read_mux
    import dbi_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_SRC-1:0] ena_i,
    input  logic [NUM_SRC-1:0] str_i,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic               idle_dis_i,
    input  logic [REG_W-1:0]   hp_word_i,
    input  logic [REG_W-1:0]   prio_rdata_i,
    input  logic               prio_hit_i,
    output logic [REG_W-1:0]   rdata_o
);
    localparam int PAD_W = 2 * REG_W;

    logic [PAD_W-1:0] ena_p, str_p, pend_p, irqv, fiqv;

    // Widen both banks to 64 bits and form the steered pending views.
    always_comb begin
        ena_p  = {{(PAD_W-NUM_SRC){1'b0}}, ena_i};
        str_p  = {{(PAD_W-NUM_SRC){1'b0}}, str_i};
        pend_p = {{(PAD_W-NUM_SRC){1'b0}}, pend_i};
        irqv   = pend_p & ~str_p & ena_p;
        fiqv   = pend_p &  str_p & ena_p;
    end

    // Offset decode.
    always_comb begin
        unique case (addr_i)
            OFS_IRQ_LO: rdata_o = irqv[REG_W-1:0];
            OFS_IRQ_HI: rdata_o = irqv[PAD_W-1:REG_W];
            OFS_FIQ_LO: rdata_o = fiqv[REG_W-1:0];
            OFS_FIQ_HI: rdata_o = fiqv[PAD_W-1:REG_W];
            OFS_RAW_LO: rdata_o = pend_p[REG_W-1:0];
            OFS_RAW_HI: rdata_o = pend_p[PAD_W-1:REG_W];
            OFS_ENA_LO: rdata_o = ena_p[REG_W-1:0];
            OFS_ENA_HI: rdata_o = ena_p[PAD_W-1:REG_W];
            OFS_STR_LO: rdata_o = str_p[REG_W-1:0];
            OFS_STR_HI: rdata_o = str_p[PAD_W-1:REG_W];
            OFS_CTRL:   rdata_o = {31'b0, idle_dis_i};
            OFS_WINNER: rdata_o = hp_word_i;
            default:    rdata_o = prio_hit_i ? prio_rdata_i : '0;
        endcase
    end
endmodule

// File: rtl/dbank_intc.sv
// Top of the two-bank interrupt controller: source bank state, priority table
// and read decode. Writes take effect at the clock edge; reads are combinational.
module dbank_intc
    import dbi_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               halted_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [REG_W-1:0]   bus_wdata_i,
    output logic [REG_W-1:0]   bus_rdata_o,
    input  logic [REG_W-1:0]   hp_word_i,
    output logic               fiq_o,
    output logic               irq_o,
    output logic               wake_o
);
    logic [NUM_SRC-1:0] ena_w, str_w, pend_w;
    logic               idle_dis_w;
    logic [REG_W-1:0]   prio_rdata;
    logic               prio_hit;

    dbi_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_i      (src_i),
        .halted_i   (halted_i),
        .wr_i       (bus_wr_i),
        .waddr_i    (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .ena_o      (ena_w),
        .str_o      (str_w),
        .pend_o     (pend_w),
        .idle_dis_o (idle_dis_w),
        .fiq_o      (fiq_o),
        .irq_o      (irq_o),
        .wake_o     (wake_o)
    );

    dbi_prio_table #(.NUM_SRC(NUM_SRC)) u_prio (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .rdata_o (prio_rdata),
        .hit_o   (prio_hit)
    );

    dbi_read_mux #(.NUM_SRC(NUM_SRC)) u_rmux (
        .addr_i       (bus_addr_i),
        .ena_i        (ena_w),
        .str_i        (str_w),
        .pend_i       (pend_w),
        .idle_dis_i   (idle_dis_w),
        .hp_word_i    (hp_word_i),
        .prio_rdata_i (prio_rdata),
        .prio_hit_i   (prio_hit),
        .rdata_o      (bus_rdata_o)
    );
endmodule

// File: rtl/dbank_intc_chk.sv
// Checker for dbank_intc: relates the registered requests to the inputs and
// stored enable/steering/control state of the previous cycle.
module dbank_intc_chk #(
    parameter int NUM_SRC = 40
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src,
    input logic               halted,
    input logic [NUM_SRC-1:0] ena,
    input logic [NUM_SRC-1:0] str,
    input logic               idle_dis,
    input logic               fiq,
    input logic               irq,
    input logic               wake
);
    logic up;

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) up <= 1'b0;
        else        up <= 1'b1;
    end

    // R3: fast request follows last cycle's enabled, steered-fast inputs.
    assert_fiq_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        up |-> (fiq == $past(|(src & ena & str))));

    // R4: normal request follows last cycle's enabled, steered-normal inputs.
    assert_irq_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        up |-> (irq == $past(|(src & ena & ~str))));

    // R7: wake follows halted and the idle-mask widened source set.
    assert_wake_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        up |-> (wake == $past(halted & (|(src & (ena | {NUM_SRC{~idle_dis}}))))));

    // R9: the first cycle out of reset sees cleared state and quiet outputs.
    assert_reset_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up) |-> ($past(ena) == '0 && $past(str) == '0 && !$past(idle_dis)
                       && !$past(fiq) && !$past(irq) && !$past(wake)));
endmodule

bind dbank_intc dbank_intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .src      (src_i),
    .halted   (halted_i),
    .ena      (ena_w),
    .str      (str_w),
    .idle_dis (idle_dis_w),
    .fiq      (fiq_o),
    .irq      (irq_o),
    .wake     (wake_o)
);

// File: tb/test_dbank_intc.sv
// Directed bench for dbank_intc: one task per scenario, each checking itself.
module test_dbank_intc;
    localparam int NS = 40;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NS-1:0] src;
    logic          halted;
    logic          wr;
    logic [7:0]    addr;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic [31:0]   hp_word;
    logic          fiq, irq, wake;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    dbank_intc #(.NUM_SRC(NS)) i_dbank_intc (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .src_i       (src),
        .halted_i    (halted),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .hp_word_i   (hp_word),
        .fiq_o       (fiq),
        .irq_o       (irq),
        .wake_o      (wake)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    // One rising edge, then back to the falling edge for sampling/driving.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Register write landing at the next rising edge.
    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        step();
        wr = 1'b0; addr = 8'hFC; wdata = '0;
    endtask

    // Combinational read sampled mid-cycle.
    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
        addr = 8'hFC;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd_reg(a, v);
        check(req, $sformatf("read 0x%02h", a), v, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        check("R9", "fiq after reset", {31'b0, fiq}, 0);
        check("R9", "irq after reset", {31'b0, irq}, 0);
        check("R9", "wake after reset", {31'b0, wake}, 0);
        rd_check("R9", 8'h04, 0);
        rd_check("R9", 8'h08, 0);
        rd_check("R9", 8'h10, 0);
        rd_check("R9", 8'h14, 0);
        rd_check("R9", 8'h1C, 0);
        rd_check("R9", 8'hCC, 0);
    endtask

    task automatic t_steer();
        src = '0; src[3] = 1'b1;
        wr_reg(8'h04, 32'h8);          // enable source 3, steering 0
        step();
        check("R4", "irq with source 3 normal", {31'b0, irq}, 1);
        check("R3", "fiq with source 3 normal", {31'b0, fiq}, 0);
        wr_reg(8'h08, 32'h8);          // steer source 3 fast
        step();
        check("R3", "fiq with source 3 fast", {31'b0, fiq}, 1);
        check("R4", "irq with source 3 fast", {31'b0, irq}, 0);
        src[3] = 1'b0;                 // input drops, one edge
        step();
        check("R3", "fiq after input low", {31'b0, fiq}, 0);
        src[5] = 1'b1;                 // high but disabled
        step();
        check("R4", "irq with disabled source", {31'b0, irq}, 0);
        check("R3", "fiq with disabled source", {31'b0, fiq}, 0);
        src = '0;
        wr_reg(8'h04, 0);
        wr_reg(8'h08, 0);
    endtask

    task automatic t_pending();
        src = '0; src[0] = 1'b1; src[17] = 1'b1; src[31] = 1'b1;
        step();
        rd_check("R2", 8'h10, 32'h8002_0001);
        src[17] = 1'b0;
        step();
        rd_check("R2", 8'h10, 32'h8000_0001);
        src = '0;
        step();
        rd_check("R2", 8'h10, 0);
    endtask

    task automatic t_high_bank();
        src = '0; src[35] = 1'b1;
        step();
        rd_check("R1", 8'hAC, 32'h8);
        rd_check("R1", 8'h10, 0);
        wr_reg(8'hA0, 32'h8);
        step();
        check("R1", "irq from source 35", {31'b0, irq}, 1);
        rd_check("R5", 8'h9C, 32'h8);
        wr_reg(8'hA4, 32'h8);
        step();
        check("R3", "fiq from source 35", {31'b0, fiq}, 1);
        rd_check("R5", 8'hA8, 32'h8);
        rd_check("R5", 8'h9C, 0);
        wr_reg(8'hA0, 32'hFFFF_FFFF);
        rd_check("R6", 8'hA0, 32'hFF);
        rd_check("R6", 8'hA4, 32'h8);
        src = '0;
        wr_reg(8'hA0, 0);
        wr_reg(8'hA4, 0);
    endtask

    task automatic t_views();
        src = '0; src[1] = 1'b1; src[2] = 1'b1; src[4] = 1'b1;
        wr_reg(8'h04, 32'h6);
        wr_reg(8'h08, 32'h4);
        rd_check("R6", 8'h04, 32'h6);
        rd_check("R6", 8'h08, 32'h4);
        rd_check("R5", 8'h00, 32'h2);
        rd_check("R5", 8'h0C, 32'h4);
        rd_check("R2", 8'h10, 32'h16);
        step();
        check("R3", "fiq mixed", {31'b0, fiq}, 1);
        check("R4", "irq mixed", {31'b0, irq}, 1);
        src = '0;
        wr_reg(8'h04, 0);
        wr_reg(8'h08, 0);
    endtask

    task automatic t_idle();
        src = '0; src[6] = 1'b1; halted = 1'b1;
        step();
        check("R7", "wake disabled source, idle mask on", {31'b0, wake}, 1);
        wr_reg(8'h14, 32'h1);
        rd_check("R7", 8'h14, 32'h1);
        step();
        check("R7", "wake disabled source, idle mask off", {31'b0, wake}, 0);
        wr_reg(8'h04, 32'h40);
        step();
        check("R7", "wake enabled source", {31'b0, wake}, 1);
        halted = 1'b0;
        step();
        check("R7", "wake while running", {31'b0, wake}, 0);
        src = '0;
        wr_reg(8'h04, 0);
        wr_reg(8'h14, 0);
        rd_check("R7", 8'h14, 0);
    endtask

    task automatic t_prio();
        wr_reg(8'h1C + 8'd20, 32'hFFFF_FFFF);    // entry 5
        rd_check("R8", 8'h30, 32'h8000_003F);
        wr_reg(8'hCC, 32'h1234_5678);            // entry 39
        rd_check("R8", 8'hCC, 32'h0000_0038);
        wr_reg(8'hB0, 32'h8000_0027);            // entry 32
        rd_check("R8", 8'hB0, 32'h8000_0027);
        rd_check("R8", 8'h98, 0);                // entry 31 untouched
    endtask

    task automatic t_unmapped();
        wr_reg(8'h04, 32'h5);
        wr_reg(8'hD0, 32'hFFFF_FFFF);
        wr_reg(8'h0E, 32'hFFFF_FFFF);
        rd_check("R10", 8'hD0, 0);
        rd_check("R10", 8'h0E, 0);
        rd_check("R10", 8'h04, 32'h5);
        rd_check("R10", 8'h08, 0);
        src = '0;
        wr_reg(8'h10, 32'hFFFF_FFFF);
        wr_reg(8'h18, 32'hFFFF_FFFF);
        rd_check("R10", 8'h10, 0);
        hp_word = 32'hA5A5_0003;
        rd_check("R10", 8'h18, 32'hA5A5_0003);
        step();
        check("R10", "no request after read-only writes", {30'b0, fiq, irq}, 0);
        wr_reg(8'h04, 0);
    endtask

    initial begin
        rst_n = 1'b0; src = '0; halted = 1'b0;
        wr = 1'b0; addr = 8'hFC; wdata = '0; hp_word = '0;
        @(negedge clk);
        t_reset();
        t_steer();
        t_pending();
        t_high_bank();
        t_views();
        t_idle();
        t_prio();
        t_unmapped();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule